// File: doc/BRIEF.md
# Dual-Lane Accumulator Interpolator

This block is a small arithmetic helper on a word-addressed register bus. It holds two 32-bit accumulators, three base registers and two lane control words. Each lane selects an accumulator, shifts it right and keeps a chosen bit field. It can sign-extend that field, and it adds a base to form the lane result. A third result adds base 2 to the processed values of both lanes. Software uses it to step through tables and fixed-point sequences without spending processor instructions on shifts and masks.

Results come out through two kinds of read port. A PEEK read has no side effect. A POP read also loads the lane results back into both accumulators in the same access. Each lane can take the opposite accumulator as its input, and it can load its accumulator from the opposite lane's result on a POP. A pair of add ports adds a 24-bit value to an accumulator in one cycle. A status word reports whether the mask threw away set high bits.

Top module: `interp_unit`

Word addresses: 0/1 accumulator 0/1, 2/3/4 base 0/1/2, 5/6/7 PEEK lane 0/lane 1/combined, 8/9/10 POP lane 0/lane 1/combined, 11/12 lane 0/1 control, 13/14 add to accumulator 0/1, 15 status.

Control word fields:
- shift amount in [4:0]
- mask low index in [12:8]
- mask high index in [20:16]
- sign-extend in [24]
- cross input in [25]
- cross result in [26]
- raw add in [27]
- force in [29:28]

## Requirements
- R1: After reset, the accumulators, bases and control words are zero, so PEEK lane 0 (address 5), accumulator 0 (address 0) and status (address 15) all read 0.
- R2: A lane shifts its input right by control[4:0] with zero fill. It then keeps only bits control[12:8] through control[20:16], both ends included. All other bits become zero, and no bit survives when the low index exceeds the high index. Base plus that value, modulo 2^32, is read at PEEK address 5 or 6.
- R3: With control[24] set, the kept field is sign-extended from bit control[20:16]. If that bit is 1, every bit above it is set.
- R4: With control[25] set, the lane takes the other lane's accumulator as its input instead of its own.
- R5: With control[27] set, the lane adds its input accumulator to the base with no shift and no mask.
- R6: Lane control[29:28] is ORed into bits 29:28 of that lane's PEEK and POP read data only. The value loaded into an accumulator by a POP does not carry it.
- R7: A read of PEEK addresses 5, 6 or 7 leaves both accumulators unchanged.
- R8: A read of any POP address (8, 9, 10) returns the same data as the matching PEEK. At the next clock edge it loads each accumulator with its own lane result, or with the other lane's result when that lane's control[26] is set.
- R9: A write to address 13 or 14 adds bits 23:0 of the write data, zero-extended, to accumulator 0 or 1, modulo 2^32. Bits 31:24 of the write data have no effect.
- R10: Status bit 0 (or bit 1) is set when accumulator 0 (or 1), shifted right by its own lane's shift, has a 1 above that lane's mask high index. Status bit 2 is the OR of bits 0 and 1.
- R11: The combined result at address 7 is base 2 plus both lanes' processed values, taken before their own bases are added, modulo 2^32.
- R12: A register write takes effect at the next clock edge, and a PEEK in the following cycle reflects it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; triggers the POP side effect |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |

## Verification
The bench targets the mask edges, including a 32-bit field, a shift of 31 and an empty mask with the low index above the high index. A design with an off-by-one inclusive bound would leak or drop an edge bit. It checks sign extension with the field's top bit both set and clear, and a wrong extension point would corrupt the upper bits. It checks that POP with cross-result swaps values and that forced bits never reach the accumulators. A design that wrote back the bus value would leave 0x3 in bits 29:28. It also checks that the add port ignores the top byte and wraps.

// File: rtl/interp_unit.sv
module interp_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata
);
  localparam logic [31:0] CTRL_KEEP = 32'h3F1F_1F1F;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic [31:0] acc  [2];
  logic [31:0] base [3];
  logic [31:0] ctrl [2];
  logic [31:0] proc [2];
  logic [31:0] res  [2];
  logic [31:0] pres [2];
  logic [1:0]  ovf;
  logic [31:0] res2;

  for (genvar k = 0; k < 2; k++) begin : g_lane
    logic [4:0]  sh, lsb, msb;
    logic [31:0] src, shifted, upper, keep, masked;
    assign sh      = ctrl[k][4:0];
    assign lsb     = ctrl[k][12:8];
    assign msb     = ctrl[k][20:16];
    assign src     = ctrl[k][25] ? acc[(k == 0) ? 1 : 0] : acc[k];
    assign shifted = src >> sh;
    assign upper   = ~(ONES >> (5'd31 - msb));
    assign keep    = (ONES << lsb) & ~upper;
    assign masked  = shifted & keep;
    assign proc[k] = ctrl[k][27] ? src :
                     (ctrl[k][24] && masked[msb]) ? (masked | upper) : masked;
    assign res[k]  = base[k] + proc[k];
    assign pres[k] = res[k] | {2'b00, ctrl[k][29:28], 28'd0};
    assign ovf[k]  = |((acc[k] >> sh) & upper);
  end

  assign res2 = base[2] + proc[0] + proc[1];

  always_comb begin
    case (bus_addr)
      4'd0:       bus_rdata = acc[0];
      4'd1:       bus_rdata = acc[1];
      4'd2:       bus_rdata = base[0];
      4'd3:       bus_rdata = base[1];
      4'd4:       bus_rdata = base[2];
      4'd5, 4'd8: bus_rdata = pres[0];
      4'd6, 4'd9: bus_rdata = pres[1];
      4'd7, 4'd10: bus_rdata = res2;
      4'd11:      bus_rdata = ctrl[0];
      4'd12:      bus_rdata = ctrl[1];
      4'd15:      bus_rdata = {29'd0, |ovf, ovf};
      default:    bus_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        acc[i]  <= 32'd0;
        ctrl[i] <= 32'd0;
      end
      for (int i = 0; i < 3; i++) base[i] <= 32'd0;
    end else begin
      if (bus_wr) begin
        case (bus_addr)
          4'd0:  acc[0]  <= bus_wdata;
          4'd1:  acc[1]  <= bus_wdata;
          4'd2:  base[0] <= bus_wdata;
          4'd3:  base[1] <= bus_wdata;
          4'd4:  base[2] <= bus_wdata;
          4'd11: ctrl[0] <= bus_wdata & CTRL_KEEP;
          4'd12: ctrl[1] <= bus_wdata & CTRL_KEEP;
          4'd13: acc[0]  <= acc[0] + {8'd0, bus_wdata[23:0]};
          4'd14: acc[1]  <= acc[1] + {8'd0, bus_wdata[23:0]};
          default: ;
        endcase
      end
      if (bus_rd && (bus_addr == 4'd8 || bus_addr == 4'd9 || bus_addr == 4'd10)) begin
        acc[0] <= ctrl[0][26] ? res[1] : res[0];
        acc[1] <= ctrl[1][26] ? res[0] : res[1];
      end
    end
  end
endmodule

// File: rtl/interp_unit_chk.sv
module interp_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [3:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic [31:0] acc0,
  input logic [31:0] acc1,
  input logic [31:0] res0,
  input logic        xres0,
  input logic [1:0]  frc0
);
  p_acc_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 4'd0 |=> acc0 == $past(bus_wdata));

  p_peek_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && (bus_addr == 4'd5 || bus_addr == 4'd6 || bus_addr == 4'd7)
    |=> $stable(acc0) && $stable(acc1));

  p_pop_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && !bus_wr && bus_addr == 4'd8 && !xres0 |=> acc0 == $past(res0));

  p_add_port_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == 4'd13 |=> acc0 == $past(acc0) + {8'd0, $past(bus_wdata[23:0])});

  p_force_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr == 4'd5 |-> (bus_rdata[29:28] & frc0) == frc0);
endmodule

bind interp_unit interp_unit_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .acc0(acc[0]), .acc1(acc[1]), .res0(res[0]),
  .xres0(ctrl[0][26]), .frc0(ctrl[0][29:28])
);

// File: tb/interp_unit_tb.sv
module interp_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [3:0]  bus_addr = 4'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  interp_unit dut_i (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  always #4 clk = ~clk;

  // {ctrl0, acc0, base0, expected PEEK lane 0}
  localparam logic [127:0] VEC [7] = '{
    {32'h0007_0004, 32'h1234_5678, 32'h0000_0100, 32'h0000_0167},
    {32'h000B_0400, 32'hABCD_EF12, 32'h0000_0000, 32'h0000_0F10},
    {32'h0107_0008, 32'h0000_8000, 32'h0000_0010, 32'hFFFF_FF90},
    {32'h0107_0008, 32'h0000_7F00, 32'h0000_0010, 32'h0000_008F},
    {32'h0800_0003, 32'h0000_0010, 32'h0000_0005, 32'h0000_0015},
    {32'h001F_001F, 32'h8000_0000, 32'hFFFF_FFFF, 32'h0000_0000},
    {32'h0004_0800, 32'hFFFF_FFFF, 32'h0000_0007, 32'h0000_0007}
  };
  localparam string VTAG [7] = '{"R2", "R2", "R3", "R3", "R5", "R2", "R2"};

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] got;
    rd(a, got);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s addr %0d: got %h expected %h", tag, a, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(4'd5, 32'd0, "R1");
    chk(4'd0, 32'd0, "R1");
    chk(4'd15, 32'd0, "R1");

    for (int i = 0; i < 7; i++) begin
      wr(4'd11, VEC[i][127:96]);
      wr(4'd0, VEC[i][95:64]);
      wr(4'd2, VEC[i][63:32]);
      chk(4'd5, VEC[i][31:0], VTAG[i]);
    end

    // R4 cross input
    wr(4'd11, 32'h021F_0000); wr(4'd0, 32'd1); wr(4'd1, 32'h55); wr(4'd2, 32'd0);
    chk(4'd5, 32'h55, "R4");

    // R11 combined result
    wr(4'd11, 32'h001F_0000); wr(4'd12, 32'h001F_0000);
    wr(4'd0, 32'h10); wr(4'd1, 32'h20);
    wr(4'd2, 32'd1); wr(4'd3, 32'd2); wr(4'd4, 32'h100);
    chk(4'd7, 32'h130, "R11");
    chk(4'd6, 32'h22, "R11");

    // R7 peek leaves state
    chk(4'd5, 32'h11, "R7");
    chk(4'd5, 32'h11, "R7");
    chk(4'd0, 32'h10, "R7");

    // R6 force on bus only, R8 pop
    wr(4'd11, 32'h301F_0000);
    chk(4'd5, 32'h3000_0011, "R6");
    chk(4'd8, 32'h3000_0011, "R8");
    chk(4'd0, 32'h11, "R6");
    chk(4'd1, 32'h22, "R8");

    // R8 cross result
    wr(4'd11, 32'h001F_0000); wr(4'd12, 32'h041F_0000);
    chk(4'd9, 32'h24, "R8");
    chk(4'd0, 32'h12, "R8");
    chk(4'd1, 32'h12, "R8");

    // R9 add port
    wr(4'd0, 32'hFFFF_FFF0); wr(4'd13, 32'hFF00_0020);
    chk(4'd0, 32'h10, "R9");

    // R10 overflow flags
    wr(4'd11, 32'h0007_0000); wr(4'd0, 32'h100);
    chk(4'd15, 32'h5, "R10");
    wr(4'd0, 32'hFF);
    chk(4'd15, 32'h0, "R10");

    // R12 write visible next cycle
    wr(4'd11, 32'h001F_0000); wr(4'd0, 32'd5); wr(4'd2, 32'h1000);
    chk(4'd5, 32'h1005, "R12");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule